// File: doc/BRIEF.md
# Eight-Way Redundant Result Voter

This block sits at the retirement point of a group of lockstep execution lanes that run the same operation on the same operands. Each time the lanes present a set of results, the voter compares every lane word against lane 0 with a bitwise XOR and raises a mismatch flag if any difference is nonzero. It then looks for a value that a strict majority of lanes produced. Comparison is done per whole word, not per bit.

If all lanes agree, the value is committed on the next clock edge. If a strict majority agrees but some lanes dissent, the voter spends one extra cycle in correction. During that cycle it drives a write-back strobe, a mask of the dissenting lanes and the agreed value, and it holds every lane stalled. It commits on the edge after that. If no value reaches a strict majority, it requests a rollback so that all lanes recompute. Failures with no majority are counted. Once the retry budget is spent, the next such failure asks a slower trusted lane for the result. The voter keeps the lanes stalled until that result arrives and then commits it. A saturating counter records how many evaluations showed any disagreement.

Top module: `redundant_voter`

## Requirements
- R1: While reset is held and after it is released, commit_valid, commit_result, mismatch, wb_en, wb_mask, wb_value, stall_all, retry_req, fallback_req and mismatch_count are all zero.
- R2: When in_valid is sampled with all lanes equal, commit_valid pulses high for one cycle after that edge and commit_result holds the common value. At the same time mismatch is 0, stall_all is 0 and wb_en is 0.
- R3: mismatch is updated on every evaluated result set and holds until the next one. It is 1 exactly when some lane word differs from the lane 0 word (a nonzero XOR).
- R4: When at least NUM_LANES/2+1 lanes (5 of 8) agree and the others differ, the cycle after the evaluating edge has wb_en=1, wb_value equal to the agreed value, and wb_mask bit i set exactly for each lane i that differs. Lane i occupies lane_results bits [i*64 +: 64]. commit_valid pulses one cycle later with the agreed value.
- R5: stall_all is high throughout the correction cycle. in_valid and lane data presented during that cycle are ignored: the value committed is the agreed one, and no evaluation is counted.
- R6: When no value reaches a strict majority (4 of 8 or fewer), commit_valid stays low, mismatch is 1, and either retry_req pulses high for one cycle or fallback_req rises (see R7).
- R7: The first MAX_RETRY (3) consecutive evaluations with no majority each raise retry_req. The next one raises fallback_req instead of retry_req. Any commit clears the consecutive count.
- R8: After fallback_req rises, fallback_req and stall_all stay high and in_valid is ignored until fb_valid is sampled. On the edge where fb_valid is sampled, commit_valid pulses with commit_result equal to fb_result, and fallback_req and stall_all fall.
- R9: mismatch_count increments by one on each evaluation that has mismatch = 1 and saturates at 2^STAT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lane results are present for evaluation |
| lane_results | input | NUM_LANES*DATA_W | Lane i result at bits [i*DATA_W +: DATA_W] |
| fb_valid | input | 1 | Trusted-lane result is present |
| fb_result | input | DATA_W | Trusted-lane result |
| commit_valid | output | 1 | One-cycle commit strobe |
| commit_result | output | DATA_W | Last committed value |
| mismatch | output | 1 | Last evaluation showed disagreement |
| wb_en | output | 1 | Write-back strobe to dissenting lanes |
| wb_mask | output | NUM_LANES | Lanes to overwrite |
| wb_value | output | DATA_W | Value to write back |
| stall_all | output | 1 | Hold every lane |
| retry_req | output | 1 | Roll back and recompute request |
| fallback_req | output | 1 | Request to the trusted lane |
| mismatch_count | output | STAT_W | Saturating disagreement count |

## Verification
The bound checker checks the following on every cycle:
- A write-back strobe is always accompanied by a stall.
- A write-back strobe carries a mask that marks a nonempty minority of lanes.
- A write-back strobe is always followed by a commit of the written-back value.
- A retry never coincides with a commit.
- A pending fallback request keeps the lanes stalled and is held until the trusted result arrives.

Some behaviours can only be shown by the bench's scenarios:
- That the chosen value and mask are the right ones for a given split of lanes, including when lane 0 is the dissenter.
- That the fourth consecutive failure, and not the third, escalates.
- That a commit resets the retry budget.
- That data offered during correction or fallback is ignored.
- That the disagreement counter saturates.

// File: rtl/voter_pkg.sv
package voter_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_FIX     = 2'd1,
      ST_WAIT_FB = 2'd2
   } vstate_e;
endpackage

// File: rtl/majority_voter.sv
module majority_voter #(
   parameter int NUM_LANES = 8,
   parameter int DATA_W    = 64
) (
   input  logic [NUM_LANES*DATA_W-1:0] lanes,
   output logic                        any_diff,
   output logic                        have_major,
   output logic [DATA_W-1:0]           major_value,
   output logic [NUM_LANES-1:0]        dissent
);
   localparam int CNT_W  = $clog2(NUM_LANES + 1);
   localparam int THRESH = NUM_LANES / 2;

   logic [DATA_W-1:0]    lane_w [NUM_LANES];
   logic [NUM_LANES-1:0] differs;
   logic [NUM_LANES-1:0] cand;
   logic [CNT_W-1:0]     votes  [NUM_LANES];

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      assign lane_w[i]  = lanes[i*DATA_W +: DATA_W];
      assign differs[i] = |(lane_w[i] ^ lane_w[0]);

      always_comb begin
         votes[i] = '0;
         for (int j = 0; j < NUM_LANES; j++)
            votes[i] = votes[i] + CNT_W'(lane_w[i] == lane_w[j]);
      end
      assign cand[i] = votes[i] > CNT_W'(THRESH);
   end

   assign any_diff   = |differs;
   assign have_major = |cand;

   always_comb begin
      major_value = lane_w[0];
      for (int k = NUM_LANES - 1; k >= 0; k--)
         if (cand[k]) major_value = lane_w[k];
   end

   for (genvar m = 0; m < NUM_LANES; m++) begin : g_mask
      assign dissent[m] = have_major && (lane_w[m] != major_value);
   end
endmodule

// File: rtl/voter_ctrl.sv
module voter_ctrl
   import voter_pkg::*;
#(
   parameter int NUM_LANES = 8,
   parameter int DATA_W    = 64,
   parameter int MAX_RETRY = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic                 any_diff,
   input  logic                 have_major,
   input  logic [DATA_W-1:0]    major_value,
   input  logic [NUM_LANES-1:0] dissent,
   input  logic                 fb_valid,
   input  logic [DATA_W-1:0]    fb_result,
   output logic                 commit_valid,
   output logic [DATA_W-1:0]    commit_result,
   output logic                 mismatch,
   output logic                 wb_en,
   output logic [NUM_LANES-1:0] wb_mask,
   output logic [DATA_W-1:0]    wb_value,
   output logic                 stall_all,
   output logic                 retry_req,
   output logic                 fallback_req,
   output logic                 eval_diff
);
   localparam int RC_W = $clog2(MAX_RETRY + 1);

   vstate_e         state;
   logic [RC_W-1:0] fails;

   assign eval_diff = (state == ST_IDLE) && in_valid && any_diff;

   always_ff @(posedge clk) begin
      if (rst) begin
         state         <= ST_IDLE;
         fails         <= '0;
         commit_valid  <= 1'b0;
         commit_result <= '0;
         mismatch      <= 1'b0;
         wb_en         <= 1'b0;
         wb_mask       <= '0;
         wb_value      <= '0;
         stall_all     <= 1'b0;
         retry_req     <= 1'b0;
         fallback_req  <= 1'b0;
      end else begin
         commit_valid <= 1'b0;
         wb_en        <= 1'b0;
         retry_req    <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  mismatch <= any_diff;
                  wb_mask  <= '0;
                  if (have_major && any_diff) begin
                     wb_en     <= 1'b1;
                     wb_mask   <= dissent;
                     wb_value  <= major_value;
                     stall_all <= 1'b1;
                     state     <= ST_FIX;
                  end else if (have_major) begin
                     commit_valid  <= 1'b1;
                     commit_result <= major_value;
                     fails         <= '0;
                  end else if (fails == RC_W'(MAX_RETRY)) begin
                     fallback_req <= 1'b1;
                     stall_all    <= 1'b1;
                     state        <= ST_WAIT_FB;
                  end else begin
                     retry_req <= 1'b1;
                     fails     <= fails + 1'b1;
                  end
               end
            end
            ST_FIX: begin
               commit_valid  <= 1'b1;
               commit_result <= wb_value;
               wb_mask       <= '0;
               stall_all     <= 1'b0;
               fails         <= '0;
               state         <= ST_IDLE;
            end
            ST_WAIT_FB: begin
               if (fb_valid) begin
                  commit_valid  <= 1'b1;
                  commit_result <= fb_result;
                  fallback_req  <= 1'b0;
                  stall_all     <= 1'b0;
                  fails         <= '0;
                  state         <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              inc,
   output logic [STAT_W-1:0] count
);
   localparam logic [STAT_W-1:0] TOP = '1;

   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (inc && count != TOP)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/redundant_voter.sv
module redundant_voter #(
   parameter int NUM_LANES = 8,
   parameter int DATA_W    = 64,
   parameter int MAX_RETRY = 3,
   parameter int STAT_W    = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   input  logic [NUM_LANES*DATA_W-1:0] lane_results,
   input  logic                        fb_valid,
   input  logic [DATA_W-1:0]           fb_result,
   output logic                        commit_valid,
   output logic [DATA_W-1:0]           commit_result,
   output logic                        mismatch,
   output logic                        wb_en,
   output logic [NUM_LANES-1:0]        wb_mask,
   output logic [DATA_W-1:0]           wb_value,
   output logic                        stall_all,
   output logic                        retry_req,
   output logic                        fallback_req,
   output logic [STAT_W-1:0]           mismatch_count
);
   if (NUM_LANES < 3) begin : g_bad_lanes
      $error("redundant_voter: NUM_LANES must be at least 3");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("redundant_voter: DATA_W must be positive");
   end
   if (MAX_RETRY < 1) begin : g_bad_retry
      $error("redundant_voter: MAX_RETRY must be at least 1");
   end
   if (STAT_W < 1) begin : g_bad_stat
      $error("redundant_voter: STAT_W must be positive");
   end

   logic                 any_diff;
   logic                 have_major;
   logic [DATA_W-1:0]    major_value;
   logic [NUM_LANES-1:0] dissent;
   logic                 eval_diff;

   majority_voter #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_vote (
      .lanes       (lane_results),
      .any_diff    (any_diff),
      .have_major  (have_major),
      .major_value (major_value),
      .dissent     (dissent)
   );

   voter_ctrl #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W), .MAX_RETRY(MAX_RETRY)) u_ctrl (
      .clk           (clk),
      .rst           (rst),
      .in_valid      (in_valid),
      .any_diff      (any_diff),
      .have_major    (have_major),
      .major_value   (major_value),
      .dissent       (dissent),
      .fb_valid      (fb_valid),
      .fb_result     (fb_result),
      .commit_valid  (commit_valid),
      .commit_result (commit_result),
      .mismatch      (mismatch),
      .wb_en         (wb_en),
      .wb_mask       (wb_mask),
      .wb_value      (wb_value),
      .stall_all     (stall_all),
      .retry_req     (retry_req),
      .fallback_req  (fallback_req),
      .eval_diff     (eval_diff)
   );

   sat_counter #(.STAT_W(STAT_W)) u_stat (
      .clk   (clk),
      .rst   (rst),
      .inc   (eval_diff),
      .count (mismatch_count)
   );
endmodule

// File: rtl/voter_chk.sv
module voter_chk #(
   parameter int NUM_LANES = 8,
   parameter int DATA_W    = 64
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 fb_valid,
   input logic                 commit_valid,
   input logic [DATA_W-1:0]    commit_result,
   input logic                 mismatch,
   input logic                 wb_en,
   input logic [NUM_LANES-1:0] wb_mask,
   input logic [DATA_W-1:0]    wb_value,
   input logic                 stall_all,
   input logic                 retry_req,
   input logic                 fallback_req
);
   localparam int MAX_DISSENT = NUM_LANES - (NUM_LANES / 2 + 1);

   assert_fix_then_commit_R4: assert property (@(posedge clk) disable iff (rst)
      wb_en |=> commit_valid && commit_result == $past(wb_value));

   assert_fix_mask_minority_R4: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> (wb_mask != '0) && ($countones(wb_mask) <= MAX_DISSENT) && mismatch);

   assert_fix_stalls_R5: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> stall_all && !commit_valid);

   assert_retry_no_commit_R6: assert property (@(posedge clk) disable iff (rst)
      retry_req |-> !commit_valid && !wb_en && mismatch && !fallback_req);

   assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0({commit_valid, retry_req, wb_en}));

   assert_fb_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (fallback_req && !fb_valid) |=> fallback_req);

   assert_fb_stalls_R8: assert property (@(posedge clk) disable iff (rst)
      fallback_req |-> stall_all);
endmodule

bind redundant_voter voter_chk #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .fb_valid      (fb_valid),
   .commit_valid  (commit_valid),
   .commit_result (commit_result),
   .mismatch      (mismatch),
   .wb_en         (wb_en),
   .wb_mask       (wb_mask),
   .wb_value      (wb_value),
   .stall_all     (stall_all),
   .retry_req     (retry_req),
   .fallback_req  (fallback_req)
);

// File: tb/redundant_voter_tb.sv
`timescale 1ns/1ps
module redundant_voter_tb;
   localparam int NL = 8;
   localparam int DW = 64;
   localparam int MR = 3;
   localparam int SW = 3;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           in_valid = 1'b0;
   logic [NL*DW-1:0] lane_results = '0;
   logic           fb_valid = 1'b0;
   logic [DW-1:0]  fb_result = '0;
   logic           commit_valid;
   logic [DW-1:0]  commit_result;
   logic           mismatch;
   logic           wb_en;
   logic [NL-1:0]  wb_mask;
   logic [DW-1:0]  wb_value;
   logic           stall_all;
   logic           retry_req;
   logic           fallback_req;
   logic [SW-1:0]  mismatch_count;

   int tests = 0;
   int fails = 0;
   int exp_cnt = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   redundant_voter #(.NUM_LANES(NL), .DATA_W(DW), .MAX_RETRY(MR), .STAT_W(SW)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .lane_results(lane_results),
      .fb_valid(fb_valid), .fb_result(fb_result),
      .commit_valid(commit_valid), .commit_result(commit_result), .mismatch(mismatch),
      .wb_en(wb_en), .wb_mask(wb_mask), .wb_value(wb_value), .stall_all(stall_all),
      .retry_req(retry_req), .fallback_req(fallback_req), .mismatch_count(mismatch_count)
   );

   task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // split=0: dissenting lanes hold distinct values; split=1: all share one wrong value
   function automatic logic [NL*DW-1:0] build(logic [DW-1:0] good, logic [NL-1:0] bad, bit split);
      logic [NL*DW-1:0] r;
      for (int i = 0; i < NL; i++)
         r[i*DW +: DW] = !bad[i] ? good : (split ? ~good : good ^ (DW'(1) << i));
      return r;
   endfunction

   task automatic eval(logic [DW-1:0] good, logic [NL-1:0] bad, bit split);
      @(negedge clk);
      in_valid     = 1'b1;
      lane_results = build(good, bad, split);
      @(posedge clk); #1;
      if (bad != '0 && exp_cnt < (1 << SW) - 1) exp_cnt++;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic t_reset();
      chk("R1", "commit_valid", DW'(commit_valid), 0);
      chk("R1", "commit_result", commit_result, 0);
      chk("R1", "mismatch", DW'(mismatch), 0);
      chk("R1", "wb_en/mask/value", DW'(wb_en) | DW'(wb_mask) | wb_value, 0);
      chk("R1", "stall/retry/fallback", DW'({stall_all, retry_req, fallback_req}), 0);
      chk("R1", "mismatch_count", DW'(mismatch_count), 0);
   endtask

   task automatic t_agree(logic [DW-1:0] v);
      eval(v, '0, 0);
      chk("R2", "commit_valid", DW'(commit_valid), 1);
      chk("R2", "commit_result", commit_result, v);
      chk("R3", "mismatch clear", DW'(mismatch), 0);
      chk("R2", "stall/wb_en", DW'({stall_all, wb_en}), 0);
      idle();
      chk("R2", "commit pulse ends", DW'(commit_valid), 0);
   endtask

   task automatic t_majority(logic [DW-1:0] v, logic [NL-1:0] bad);
      eval(v, bad, 0);
      chk("R4", "wb_en", DW'(wb_en), 1);
      chk("R4", "wb_mask", DW'(wb_mask), DW'(bad));
      chk("R4", "wb_value", wb_value, v);
      chk("R3", "mismatch set", DW'(mismatch), 1);
      chk("R5", "stall in fix", DW'(stall_all), 1);
      chk("R4", "no early commit", DW'(commit_valid), 0);
      // offer other agreeing data during correction: must be ignored
      @(negedge clk);
      lane_results = build(~v, '0, 0);
      @(posedge clk); #1;
      chk("R4", "commit after fix", DW'(commit_valid), 1);
      chk("R5", "ignored input, committed value", commit_result, v);
      chk("R5", "stall released", DW'({stall_all, wb_en}), 0);
      idle();
      chk("R5", "no commit from ignored data", DW'(commit_valid), 0);
      chk("R9", "count after fix", DW'(mismatch_count), DW'(exp_cnt));
   endtask

   task automatic fail_once(logic [DW-1:0] v, bit split, bit expect_fb, string tag);
      eval(v, 8'hF0, split);
      chk("R6", {tag, " no commit"}, DW'(commit_valid), 0);
      chk("R6", {tag, " mismatch"}, DW'(mismatch), 1);
      chk("R7", {tag, " retry_req"}, DW'(retry_req), DW'(!expect_fb));
      chk("R7", {tag, " fallback_req"}, DW'(fallback_req), DW'(expect_fb));
      idle();
      if (!expect_fb) chk("R6", {tag, " retry pulse ends"}, DW'(retry_req), 0);
   endtask

   task automatic t_fallback(logic [DW-1:0] fbv);
      fail_once(64'h1111, 0, 0, "f1");
      fail_once(64'h2222, 1, 0, "f2");
      fail_once(64'h3333, 0, 0, "f3");
      fail_once(64'h4444, 1, 1, "f4");
      chk("R8", "fallback held", DW'(fallback_req), 1);
      chk("R8", "stall held", DW'(stall_all), 1);
      eval(64'h5555, '0, 0);  // ignored while waiting
      chk("R8", "in_valid ignored", DW'(commit_valid), 0);
      chk("R8", "still waiting", DW'(fallback_req), 1);
      @(negedge clk);
      in_valid  = 1'b0;
      fb_valid  = 1'b1;
      fb_result = fbv;
      @(posedge clk); #1;
      chk("R8", "fb commit", DW'(commit_valid), 1);
      chk("R8", "fb value", commit_result, fbv);
      chk("R8", "fallback released", DW'({fallback_req, stall_all}), 0);
      @(negedge clk);
      fb_valid = 1'b0;
   endtask

   task automatic t_retry_reset();
      fail_once(64'hA1, 0, 0, "r1");
      fail_once(64'hA2, 0, 0, "r2");
      t_agree(64'hBEEF);
      fail_once(64'hA3, 0, 0, "r3");
      fail_once(64'hA4, 1, 0, "r4");
      fail_once(64'hA5, 0, 0, "r5 after commit");
      t_majority(64'hC0DE, 8'h01);
      fail_once(64'hA6, 0, 0, "r6 after fix commit");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #1;
      t_reset();
      t_agree(64'h0123_4567_89AB_CDEF);
      t_agree(64'h0);
      t_majority(64'hDEAD_BEEF_0000_0001, 8'b1000_0110);
      t_majority(64'hFFFF_0000_FFFF_0000, 8'b0000_0001);
      t_majority(64'h77, 8'b0000_0000 | 8'b0101_0000);
      chk("R9", "count before saturation", DW'(mismatch_count), DW'(exp_cnt));
      t_fallback(64'hFA11_BACC_0000_0042);
      t_retry_reset();
      chk("R9", "count saturated", DW'(mismatch_count), DW'((1 << SW) - 1));
      t_agree(64'h99);
      chk("R9", "count stays saturated", DW'(mismatch_count), DW'((1 << SW) - 1));
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule